// File: doc/BRIEF.md
# 64-Source Prioritised Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and drives two request lines toward a processor: a fast request and a normal request. Each source has a pending bit, an enable bit and a type bit that steers it to one of the two lines. Fast sources raise their line with no filtering. Normal sources carry a 4-bit priority and are gated by a 5-bit threshold, so software can hold off low-priority work without disabling sources one at a time.

Software reaches the state through a 32-bit register port with a word address. A write takes effect at the clock edge that samples it. A read returns its data on `reg_rdata` from the next edge onward. Two vector words report the source that should be serviced next and clear that source's pending bit as a side effect of the read. A force path lets software write pending bits directly, for test or for software-raised interrupts.

Top module: `vec_intc`

## Requirements
- R1: A source whose input changes level has its pending bit set to the new level at the next clock edge, and the bit then holds until another change, a force write or a vector read. If a force write and a level change hit the same bit in one cycle, the level change wins. Raw pending reads at word 18 (sources 63..32) and word 19 (sources 31..0).
- R2: `irq_fast` is high whenever any source is pending, enabled and typed fast (type bit 1). No priority or threshold is applied.
- R3: `irq_norm` considers only sources that are pending, enabled and typed normal (type bit 0). It is low when none qualify.
- R4: When the threshold (word 1) is 31, any qualifying normal source raises `irq_norm`. Otherwise `irq_norm` needs a qualifying source whose priority is strictly greater than the threshold. Priorities sit in words 8..15: word 15-g holds sources 8g..8g+7, and source s uses bits [4*(s%8)+3 : 4*(s%8)].
- R5: Writing n to word 2 sets the enable bit of source n[5:0]. Writing n to word 3 clears it. Words 2 and 3 read as zero.
- R6: Words 4/5 hold enable bits 63..32/31..0, and words 6/7 hold type bits 63..32/31..0. All four are fully writable and read back.
- R7: Word 1 keeps only the low 5 bits written. Word 0 keeps only bits 18..22 and 24 of the written value, and every other bit of word 0 reads zero.
- R8: Words 22/23 return pending AND enabled AND normal, high/low halves. Words 24/25 return pending AND enabled AND fast. Writes to words 16..19 and 22..25 change nothing.
- R9: Writing word 20 or 21 replaces pending bits 63..32 or 31..0. Both words read as zero.
- R10: A read of word 16 returns {id, 16'b0} | priority for the qualifying normal source with the highest priority. Among equal priorities the highest id wins, and the threshold is not applied. The read clears that pending bit. With no such source the read returns 0xFFFFFFFF.
- R11: A read of word 17 returns the id of the lowest-numbered qualifying fast source and clears its pending bit. With no such source the read returns 0xFFFFFFFF.
- R12: Reset clears pending, enable, type, control and all priorities, sets the threshold to 31, and leaves both request lines low.
- R13: Writes to words 0x40..0xBF have no effect. A read of word 0x40 returns 4, and reads of other unmapped words return 0. Read data appears the cycle after `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| src_in | input | 64 | Level-sensitive source inputs |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The bench checks the threshold boundary: a priority equal to the threshold, a threshold above 15 that is not 31, and the fully open value 31. A design that used >= or treated 31 as an ordinary number would assert or drop `irq_norm` on the wrong side of these cases. For the normal vector it sets up ties between equal priorities and a high-numbered, high-priority source alongside lower ones. It then checks that the read clears only the reported bit and leaves it cleared while the input stays high, so a design that re-samples the level every cycle would show the bit coming back. It also targets the order in which priority words map to source groups, the read-only pending views, and fast sources leaking into the normal path.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int DW      = 32;
  localparam int NSRC    = 64;
  localparam int PW      = 4;
  localparam int MW      = 5;
  localparam int IDW     = $clog2(NSRC);
  localparam int PER_REG = DW / PW;
  localparam int NPREG   = NSRC / PER_REG;

  localparam int W_CTL    = 0;
  localparam int W_MASK   = 1;
  localparam int W_ENNUM  = 2;
  localparam int W_DISNUM = 3;
  localparam int W_EN_HI  = 4;
  localparam int W_EN_LO  = 5;
  localparam int W_TYP_HI = 6;
  localparam int W_TYP_LO = 7;
  localparam int W_PRIO   = 8;
  localparam int W_NVEC   = 16;
  localparam int W_FVEC   = 17;
  localparam int W_RAW_HI = 18;
  localparam int W_RAW_LO = 19;
  localparam int W_FRC_HI = 20;
  localparam int W_FRC_LO = 21;
  localparam int W_NP_HI  = 22;
  localparam int W_NP_LO  = 23;
  localparam int W_FP_HI  = 24;
  localparam int W_FP_LO  = 25;
  localparam int W_VBASE  = 64;

  localparam logic [MW-1:0] MASK_OPEN = '1;
  localparam logic [DW-1:0] CTL_KEEP  = 32'h017C_0000;
  localparam logic [DW-1:0] NO_VEC    = '1;
  localparam logic [DW-1:0] VBASE_VAL = 32'd4;
endpackage

// File: rtl/vec_intc_gate.sv
module vec_intc_gate
  import vec_intc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    norm_live,
  input  logic [NSRC-1:0]    fast_live,
  input  logic [NSRC*PW-1:0] prio_flat,
  input  logic [MW-1:0]      mask,
  output logic               irq_norm,
  output logic               irq_fast
);
  logic [NSRC-1:0] above;

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign above[i] = norm_live[i] && (MW'(prio_flat[i*PW +: PW]) > mask);
  end

  assign irq_fast = |fast_live;
  assign irq_norm = (mask == MASK_OPEN) ? (|norm_live) : (|above);

  AST_NORM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (norm_live == '0) |-> !irq_norm);                               // R3
  AST_NORM_CEIL: assert property (@(posedge clk) disable iff (rst)
    ((mask != MASK_OPEN) && (mask >= MW'((1 << PW) - 1))) |-> !irq_norm); // R4
  AST_FAST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fast_live == '0) |-> !irq_fast);                               // R2
endmodule

// File: rtl/vec_intc_pick.sv
module vec_intc_pick
  import vec_intc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    norm_live,
  input  logic [NSRC-1:0]    fast_live,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic               nv_valid,
  output logic [IDW-1:0]     nv_id,
  output logic [PW-1:0]      nv_prio,
  output logic               fv_valid,
  output logic [IDW-1:0]     fv_id
);
  always_comb begin
    nv_valid = 1'b0;
    nv_id    = '0;
    nv_prio  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (norm_live[i] && (!nv_valid || (prio_flat[i*PW +: PW] >= nv_prio))) begin
        nv_valid = 1'b1;
        nv_id    = IDW'(i);
        nv_prio  = prio_flat[i*PW +: PW];
      end
    end
  end

  always_comb begin
    fv_valid = 1'b0;
    fv_id    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (fast_live[i]) begin
        fv_valid = 1'b1;
        fv_id    = IDW'(i);
      end
    end
  end

  AST_NVEC_LIVE: assert property (@(posedge clk) disable iff (rst)
    nv_valid |-> norm_live[nv_id]);                                 // R10
  AST_FVEC_LOWEST: assert property (@(posedge clk) disable iff (rst)
    fv_valid |-> (fast_live[fv_id] &&
                  ((fast_live & ((NSRC'(1) << fv_id) - NSRC'(1))) == '0))); // R11
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_norm,
  output logic              irq_fast
);
  localparam int HALF = NSRC / 2;

  logic [NSRC-1:0]    pend_q, pend_d, en_q, en_d, typ_q, typ_d, src_q;
  logic [MW-1:0]      mask_q;
  logic [DW-1:0]      ctl_q, rdata_q, rd_mux;
  logic [DW-1:0]      prio_q [NPREG];
  logic [NSRC*PW-1:0] prio_flat;
  logic [NSRC-1:0]    norm_live, fast_live;
  logic               nv_valid, fv_valid;
  logic [IDW-1:0]     nv_id, fv_id;
  logic [PW-1:0]      nv_prio;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int w);
    return a == ADDR_W'(w);
  endfunction

  for (genvar g = 0; g < NPREG; g++) begin : g_pflat
    assign prio_flat[g*DW +: DW] = prio_q[g];
  end

  assign norm_live = pend_q & en_q & ~typ_q;
  assign fast_live = pend_q & en_q & typ_q;

  vec_intc_gate u_gate (
    .clk(clk), .rst(rst), .norm_live(norm_live), .fast_live(fast_live),
    .prio_flat(prio_flat), .mask(mask_q), .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  vec_intc_pick u_pick (
    .clk(clk), .rst(rst), .norm_live(norm_live), .fast_live(fast_live),
    .prio_flat(prio_flat), .nv_valid(nv_valid), .nv_id(nv_id), .nv_prio(nv_prio),
    .fv_valid(fv_valid), .fv_id(fv_id)
  );

  // next-state of the 64-bit vectors
  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    typ_d  = typ_q;
    if (reg_wr) begin
      if (at(reg_addr, W_ENNUM))  en_d[reg_wdata[IDW-1:0]] = 1'b1;
      if (at(reg_addr, W_DISNUM)) en_d[reg_wdata[IDW-1:0]] = 1'b0;
      if (at(reg_addr, W_EN_HI))  en_d[NSRC-1:HALF] = reg_wdata;
      if (at(reg_addr, W_EN_LO))  en_d[HALF-1:0]    = reg_wdata;
      if (at(reg_addr, W_TYP_HI)) typ_d[NSRC-1:HALF] = reg_wdata;
      if (at(reg_addr, W_TYP_LO)) typ_d[HALF-1:0]    = reg_wdata;
      if (at(reg_addr, W_FRC_HI)) pend_d[NSRC-1:HALF] = reg_wdata;
      if (at(reg_addr, W_FRC_LO)) pend_d[HALF-1:0]    = reg_wdata;
    end
    if (reg_rd && at(reg_addr, W_NVEC) && nv_valid) pend_d[nv_id] = 1'b0;
    if (reg_rd && at(reg_addr, W_FVEC) && fv_valid) pend_d[fv_id] = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_in[i] != src_q[i]) pend_d[i] = src_in[i];
    end
  end

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    if (at(reg_addr, W_CTL))    rd_mux = ctl_q;
    if (at(reg_addr, W_MASK))   rd_mux = DW'(mask_q);
    if (at(reg_addr, W_EN_HI))  rd_mux = en_q[NSRC-1:HALF];
    if (at(reg_addr, W_EN_LO))  rd_mux = en_q[HALF-1:0];
    if (at(reg_addr, W_TYP_HI)) rd_mux = typ_q[NSRC-1:HALF];
    if (at(reg_addr, W_TYP_LO)) rd_mux = typ_q[HALF-1:0];
    for (int g = 0; g < NPREG; g++) begin
      if (at(reg_addr, W_PRIO + NPREG - 1 - g)) rd_mux = prio_q[g];
    end
    if (at(reg_addr, W_NVEC))
      rd_mux = nv_valid ? ((DW'(nv_id) << 16) | DW'(nv_prio)) : NO_VEC;
    if (at(reg_addr, W_FVEC))
      rd_mux = fv_valid ? DW'(fv_id) : NO_VEC;
    if (at(reg_addr, W_RAW_HI)) rd_mux = pend_q[NSRC-1:HALF];
    if (at(reg_addr, W_RAW_LO)) rd_mux = pend_q[HALF-1:0];
    if (at(reg_addr, W_NP_HI))  rd_mux = norm_live[NSRC-1:HALF];
    if (at(reg_addr, W_NP_LO))  rd_mux = norm_live[HALF-1:0];
    if (at(reg_addr, W_FP_HI))  rd_mux = fast_live[NSRC-1:HALF];
    if (at(reg_addr, W_FP_LO))  rd_mux = fast_live[HALF-1:0];
    if (at(reg_addr, W_VBASE))  rd_mux = VBASE_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      en_q    <= '0;
      typ_q   <= '0;
      src_q   <= '0;
      mask_q  <= MASK_OPEN;
      ctl_q   <= '0;
      rdata_q <= '0;
      for (int g = 0; g < NPREG; g++) prio_q[g] <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      typ_q  <= typ_d;
      src_q  <= src_in;
      if (reg_wr && at(reg_addr, W_MASK)) mask_q <= reg_wdata[MW-1:0];
      if (reg_wr && at(reg_addr, W_CTL))  ctl_q  <= reg_wdata & CTL_KEEP;
      if (reg_rd) rdata_q <= rd_mux;
      for (int g = 0; g < NPREG; g++) begin
        if (reg_wr && at(reg_addr, W_PRIO + NPREG - 1 - g)) prio_q[g] <= reg_wdata;
      end
    end
  end

  assign reg_rdata = rdata_q;

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    ((src_in ^ src_q) != '0) |=> (((pend_q ^ $past(src_in)) & $past(src_in ^ src_q)) == '0)); // R1
  AST_EN_BY_NUM: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && at(reg_addr, W_ENNUM)) |=> en_q[$past(reg_wdata[IDW-1:0])]);   // R5
  AST_DIS_BY_NUM: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && at(reg_addr, W_DISNUM)) |=> !en_q[$past(reg_wdata[IDW-1:0])]); // R5
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_rd && (src_in == src_q) &&
     (at(reg_addr, W_RAW_HI) || at(reg_addr, W_RAW_LO) || at(reg_addr, W_NP_LO) ||
      at(reg_addr, W_FP_LO))) |=> $stable(pend_q));                           // R8
  AST_NVEC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && at(reg_addr, W_NVEC) && nv_valid &&
     (src_in[nv_id] == src_q[nv_id])) |=> !pend_q[$past(nv_id)]);             // R10
endmodule

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        rd;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  r;
  } step_t;

  localparam int NSTEP = 37;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 10'd1,  32'h0,        32'h0000_001F, 8'd12}, // R12 threshold reset
    '{1'b1, 10'd0,  32'h0,        32'h0,         8'd12}, // R12 control reset
    '{1'b0, 10'd4,  32'hDEAD_BEEF, 32'h0,        8'd6},
    '{1'b1, 10'd4,  32'h0,        32'hDEAD_BEEF, 8'd6},  // R6
    '{1'b0, 10'd4,  32'h0,        32'h0,         8'd6},
    '{1'b0, 10'd1,  32'h0000_00FF, 32'h0,        8'd7},
    '{1'b1, 10'd1,  32'h0,        32'h0000_001F, 8'd7},  // R7
    '{1'b0, 10'd0,  32'hFFFF_FFFF, 32'h0,        8'd7},
    '{1'b1, 10'd0,  32'h0,        32'h017C_0000, 8'd7},  // R7
    '{1'b0, 10'd2,  32'h0000_00C5, 32'h0,        8'd5},
    '{1'b1, 10'd5,  32'h0,        32'h0000_0020, 8'd5},  // R5
    '{1'b1, 10'd2,  32'h0,        32'h0,         8'd5},  // R5
    '{1'b0, 10'd3,  32'h0000_0045, 32'h0,        8'd5},
    '{1'b1, 10'd5,  32'h0,        32'h0,         8'd5},  // R5
    '{1'b0, 10'd5,  32'h0000_0033, 32'h0,        8'd6},
    '{1'b0, 10'd7,  32'h0000_000F, 32'h0,        8'd6},
    '{1'b0, 10'd21, 32'h0000_00A5, 32'h0,        8'd9},
    '{1'b1, 10'd19, 32'h0,        32'h0000_00A5, 8'd9},  // R9
    '{1'b1, 10'd21, 32'h0,        32'h0,         8'd9},  // R9
    '{1'b0, 10'd19, 32'h0,        32'h0,         8'd8},
    '{1'b1, 10'd19, 32'h0,        32'h0000_00A5, 8'd8},  // R8
    '{1'b1, 10'd23, 32'h0,        32'h0000_0020, 8'd8},  // R8
    '{1'b1, 10'd25, 32'h0,        32'h0000_0001, 8'd8},  // R8
    '{1'b1, 10'd17, 32'h0,        32'h0,         8'd11}, // R11
    '{1'b1, 10'd25, 32'h0,        32'h0,         8'd11}, // R11
    '{1'b1, 10'd17, 32'h0,        32'hFFFF_FFFF, 8'd11}, // R11
    '{1'b1, 10'd16, 32'h0,        32'h0005_0000, 8'd10}, // R10
    '{1'b1, 10'd16, 32'h0,        32'hFFFF_FFFF, 8'd10}, // R10
    '{1'b1, 10'd19, 32'h0,        32'h0000_0084, 8'd10}, // R10
    '{1'b0, 10'd64, 32'h0000_1234, 32'h0,        8'd13},
    '{1'b1, 10'd64, 32'h0,        32'h0000_0004, 8'd13}, // R13
    '{1'b1, 10'd31, 32'h0,        32'h0,         8'd13}, // R13
    '{1'b0, 10'd7,  32'h0,        32'h0,         8'd6},
    '{1'b0, 10'd5,  32'h0,        32'h0,         8'd6},
    '{1'b0, 10'd21, 32'h0,        32'h0,         8'd9},
    '{1'b0, 10'd1,  32'h0000_001F, 32'h0,        8'd7},
    '{1'b1, 10'd6,  32'h0,        32'h0,         8'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [63:0] src_in = '0;
  logic        irq_norm, irq_fast;
  int          n_chk = 0, n_err = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_intc #(.ADDR_W(10)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
    .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = 10'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic rdchk(input int a, input logic [31:0] exp, input int req);
    logic [31:0] v;
    rd(a, v);
    chk(v, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({30'd0, irq_norm, irq_fast}, 32'd0, 12); // R12 request lines low

    for (int k = 0; k < NSTEP; k++) begin
      if (TBL[k].rd) rdchk(int'(TBL[k].a), TBL[k].e, int'(TBL[k].r));
      else wr(int'(TBL[k].a), TBL[k].d);
    end

    // R1 / R3: level input drives the normal request
    wr(2, 32'd10);
    src_in[10] = 1'b1; @(negedge clk);
    chk({31'd0, irq_norm}, 32'd1, 1);  // R1
    chk({31'd0, irq_fast}, 32'd0, 3);  // R3
    rdchk(19, 32'h0000_0400, 1);       // R1
    src_in[10] = 1'b0; @(negedge clk);
    chk({31'd0, irq_norm}, 32'd0, 1);  // R1
    rdchk(19, 32'h0, 1);               // R1

    // R4: threshold boundaries, source 10 at priority 5
    src_in[10] = 1'b1; @(negedge clk);
    wr(14, 32'h0000_0500);
    wr(1, 32'd4);  chk({31'd0, irq_norm}, 32'd1, 4); // R4 5 > 4
    wr(1, 32'd5);  chk({31'd0, irq_norm}, 32'd0, 4); // R4 equal
    wr(1, 32'd20); chk({31'd0, irq_norm}, 32'd0, 4); // R4 above 15
    wr(1, 32'd31); chk({31'd0, irq_norm}, 32'd1, 4); // R4 open

    // R10: highest priority, tie, clear persists while input stays high
    wr(2, 32'd60);
    wr(8, 32'h000F_0000);
    wr(20, 32'h1000_0000);
    wr(1, 32'd4);
    chk({31'd0, irq_norm}, 32'd1, 4);  // R4
    rdchk(16, 32'h003C_000F, 10);      // R10
    rdchk(18, 32'h0, 10);              // R10
    rdchk(16, 32'h000A_0005, 10);      // R10
    rdchk(16, 32'hFFFF_FFFF, 10);      // R10
    chk({31'd0, irq_norm}, 32'd0, 10); // R10 cleared despite high input
    wr(2, 32'd11);
    wr(14, 32'h0000_5500);
    wr(21, 32'h0000_0C00);
    rdchk(16, 32'h000B_0005, 10);      // R10 tie to higher id
    rdchk(16, 32'h000A_0005, 10);      // R10

    // R2 / R3: fast steering bypasses the threshold
    wr(7, 32'h0000_0400);
    wr(1, 32'd30);
    wr(21, 32'h0000_0400);
    chk({31'd0, irq_fast}, 32'd1, 2);  // R2
    chk({31'd0, irq_norm}, 32'd0, 3);  // R3
    rdchk(25, 32'h0000_0400, 8);       // R8
    rdchk(23, 32'h0, 8);               // R8
    wr(3, 32'd10);
    chk({31'd0, irq_fast}, 32'd0, 5);  // R5

    // R12: reset in mid-run
    src_in = '0;
    rst = 1'b1; repeat (2) @(negedge clk);
    rst = 1'b0; @(negedge clk);
    chk({30'd0, irq_norm, irq_fast}, 32'd0, 12); // R12
    rdchk(1, 32'h0000_001F, 12);       // R12
    rdchk(14, 32'h0, 12);              // R12
    rdchk(5, 32'h0, 12);               // R12
    rdchk(7, 32'h0, 12);               // R12
    rdchk(19, 32'h0, 12);              // R12

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule